// File: doc/BRIEF.md
# Receive Buffer Read Packer

This block reads packed words out of a byte-addressed receive buffer. The requester gives two operands whose sum is an address in its own address space, where the buffer occupies a window starting at 0x2000. It also gives a word count, a destination tag and a width select. The block checks the request, then walks the buffer and emits one packed word per beat on a ready/valid stream, with a last flag on the final beat. A done pulse marks completion and an error pulse marks a rejected request.

In narrow mode each beat is a 32-bit word bound for consecutive destination registers, and the tag counts up by one per beat. In wide mode each beat is a 64-bit word bound for an external memory writer, and the tag is a byte address that counts up by eight per beat. Reads never alter or release buffer contents, so the same region can be read any number of times. A simple fill port loads the buffer one 32-bit word at a time. Only one request is in flight at a time.

Top module: `rbuf_read_packer`

## Requirements
- R1: The buffer offset equals reqOpA + reqOpB − 0x2000, computed with a 17-bit sum. A request is rejected if the sum is below 0x2000, or if offset + count × (4 in narrow mode, 8 in wide mode) is greater than the buffer size (256 bytes by default).
- R2: In narrow mode (reqWide=0), beat k carries buffer bytes offset+4k .. offset+4k+3 in outData[31:0]. The lowest-offset byte is in bits 31:24 and the following bytes run toward bit 0. outData[63:32] is zero.
- R3: In wide mode (reqWide=1), beat k covers bytes o = offset+8k .. o+7. Bytes o..o+3 sit in outData[31:0] with byte o at bits 31:24. Bytes o+4..o+7 sit in outData[63:32] with byte o+4 at bits 63:56.
- R4: outDest on beat k is reqDest+k in narrow mode and reqDest+8k in wide mode, both modulo 2^16.
- R5: An accepted request with count N>0 produces exactly N beats. outLast is high on the final beat only. doneOut pulses for one cycle in the cycle after the final beat is accepted.
- R6: An offset that is not a multiple of 4 (narrow) or of 8 (wide) is rejected. Any rejected request produces a one-cycle errPulse, no beats and no doneOut.
- R7: In wide mode, a reqDest that is not a multiple of 8 is rejected.
- R8: A valid request with count zero produces a one-cycle doneOut, with no beats and no errPulse.
- R9: Reads leave the buffer unchanged. Repeating a request returns identical beats.
- R10: reqReady is high only when no request is in flight. While outValid is high and outReady is low, outValid, outDest and outLast hold their values into the next cycle.
- R11: A fill write with fillEn=1 stores fillData at word index fillIdx. fillData[31:24] is the byte at offset 4×fillIdx and fillData[7:0] is the byte at 4×fillIdx+3. Later reads return the new bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fillEn | input | 1 | Fill write strobe |
| fillIdx | input | 6 | Fill word index |
| fillData | input | 32 | Fill word, lowest-offset byte in bits 31:24 |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqWide | input | 1 | 0: 32-bit register beats, 1: 64-bit memory beats |
| reqOpA | input | 16 | First address operand |
| reqOpB | input | 16 | Second address operand |
| reqCount | input | 4 | Number of output words |
| reqDest | input | 16 | First destination register index or memory byte address |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Sink ready |
| outData | output | 64 | Packed word |
| outDest | output | 16 | Destination tag for this beat |
| outLast | output | 1 | Final beat of the request |
| errPulse | output | 1 | One-cycle rejection pulse |
| doneOut | output | 1 | One-cycle completion pulse |

## Verification
A wrong pointer or lane order shows up on the very first beat of a request as a misplaced byte in outData. The sweep exercises every aligned offset in both widths, so a byte swap or a wrong step size cannot hide behind a particular offset. A beat counter or limit error appears within the same request, as a missing or extra beat, a misplaced last flag, or a late done pulse. A fault in the rejection logic appears one cycle after acceptance, as an error pulse where beats were expected or beats where an error was expected. Stalls on the sink side are inserted every third cycle, so any state that fails to hold under backpressure is compared against the value seen one cycle earlier.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CHECK  = 2'd1,
    ST_STREAM = 2'd2,
    ST_DONE   = 2'd3
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } dpStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic reject;
    logic zeroCount;
    logic lastBeat;
  } dpStatus_t;

  localparam int unsigned WINDOW_BASE = 32'h2000;
endpackage

// File: rtl/rbuf_store.sv
module rbuf_store #(
  parameter int unsigned WORDS = 64,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          fillEn,
  input  logic [AW-1:0] fillIdx,
  input  logic [31:0]   fillData,
  input  logic [AW-1:0] rdIdxLo,
  input  logic [AW-1:0] rdIdxHi,
  output logic [31:0]   rdLo,
  output logic [31:0]   rdHi
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (fillEn) mem[fillIdx] <= fillData;
  end

  assign rdLo = mem[rdIdxLo];
  assign rdHi = mem[rdIdxHi];
endmodule

// File: rtl/rbuf_pack_dp.sv
module rbuf_pack_dp
  import rbuf_pkg::*;
#(
  parameter int unsigned OP_W      = 16,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned DEST_W    = 16,
  parameter int unsigned BUF_BYTES = 256,
  parameter int unsigned BASE      = WINDOW_BASE,
  localparam int unsigned AW    = $clog2(BUF_BYTES / 4),
  localparam int unsigned SUM_W = OP_W + 1,
  localparam int unsigned EXT_W = SUM_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              reqWide,
  input  logic [OP_W-1:0]   reqOpA,
  input  logic [OP_W-1:0]   reqOpB,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic [DEST_W-1:0] reqDest,
  input  logic [31:0]       rdLo,
  input  logic [31:0]       rdHi,
  output logic [AW-1:0]     rdIdxLo,
  output logic [AW-1:0]     rdIdxHi,
  output dpStatus_t         status,
  output logic [63:0]       outData,
  output logic [DEST_W-1:0] outDest,
  output logic              outLast
);
  logic [SUM_W-1:0]  sumQ;
  logic              wideQ;
  logic [CNT_W-1:0]  cntQ;
  logic [DEST_W-1:0] destQ;
  logic [CNT_W-1:0]  beatQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumQ  <= '0;
      wideQ <= 1'b0;
      cntQ  <= '0;
      destQ <= '0;
      beatQ <= '0;
    end else if (strobe.load) begin
      sumQ  <= SUM_W'(reqOpA) + SUM_W'(reqOpB);
      wideQ <= reqWide;
      cntQ  <= reqCount;
      destQ <= reqDest;
      beatQ <= '0;
    end else if (strobe.step) begin
      beatQ <= beatQ + CNT_W'(1);
    end
  end

  // request checks
  logic [EXT_W-1:0] offsetExt;
  logic [EXT_W-1:0] spanBytes;
  logic [EXT_W-1:0] endExt;
  logic belowBase, overRun, misaligned, destBad;

  assign offsetExt  = {1'b0, sumQ} - EXT_W'(BASE);
  assign spanBytes  = wideQ ? (EXT_W'(cntQ) << 3) : (EXT_W'(cntQ) << 2);
  assign endExt     = offsetExt + spanBytes;
  assign belowBase  = sumQ < SUM_W'(BASE);
  assign overRun    = endExt > EXT_W'(BUF_BYTES);
  assign misaligned = wideQ ? (offsetExt[2:0] != 3'd0) : (offsetExt[1:0] != 2'd0);
  assign destBad    = wideQ && (destQ[2:0] != 3'd0);

  assign status.reject    = belowBase || overRun || misaligned || destBad;
  assign status.zeroCount = (cntQ == '0);
  assign status.lastBeat  = (beatQ == cntQ - CNT_W'(1));

  // buffer addressing
  logic [AW-1:0] wordBase;
  logic [AW-1:0] beatWords;
  assign wordBase  = offsetExt[AW+1:2];
  assign beatWords = wideQ ? AW'({beatQ, 1'b0}) : AW'(beatQ);
  assign rdIdxLo   = wordBase + beatWords;
  assign rdIdxHi   = rdIdxLo + AW'(1);

  // lane packing
  assign outData = wideQ ? {rdHi, rdLo} : {32'h0, rdLo};
  assign outDest = wideQ ? destQ + (DEST_W'(beatQ) << 3) : destQ + DEST_W'(beatQ);
  assign outLast = status.lastBeat;

  // R5: control never steps beyond the requested count
  a_r5_step_in_range: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> (beatQ < cntQ));

  // R10: captured request fields stay put while no new request is loaded
  a_r10_fields_hold: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> $stable(cntQ) && $stable(destQ) && $stable(wideQ));
endmodule

// File: rtl/rbuf_read_ctrl.sv
module rbuf_read_ctrl
  import rbuf_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      outReady,
  input  dpStatus_t status,
  output logic      reqReady,
  output logic      outValid,
  output logic      errPulse,
  output logic      doneOut,
  output dpStrobe_t strobe
);
  ctrlState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD      = stateQ;
    reqReady    = 1'b0;
    outValid    = 1'b0;
    errPulse    = 1'b0;
    doneOut     = 1'b0;
    strobe.load = 1'b0;
    strobe.step = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        reqReady    = 1'b1;
        strobe.load = reqValid;
        if (reqValid) stateD = ST_CHECK;
      end
      ST_CHECK: begin
        if (status.reject) begin
          errPulse = 1'b1;
          stateD   = ST_IDLE;
        end else if (status.zeroCount) begin
          doneOut = 1'b1;
          stateD  = ST_IDLE;
        end else begin
          stateD = ST_STREAM;
        end
      end
      ST_STREAM: begin
        outValid    = 1'b1;
        strobe.step = outReady;
        if (outReady && status.lastBeat) stateD = ST_DONE;
      end
      ST_DONE: begin
        doneOut = 1'b1;
        stateD  = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  // R10: a stalled beat stays offered
  a_r10_valid_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  // R6: error is a single-cycle pulse and never overlaps data
  a_r6_err_single: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |=> !errPulse);
  a_r6_err_no_beat: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> !outValid && !doneOut);

  // R5: completion follows the final accepted beat
  a_r5_last_then_done: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && status.lastBeat) |=> doneOut);
endmodule

// File: rtl/rbuf_read_packer.sv
module rbuf_read_packer
  import rbuf_pkg::*;
#(
  parameter int unsigned OP_W      = 16,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned DEST_W    = 16,
  parameter int unsigned BUF_BYTES = 256,
  parameter int unsigned BASE      = WINDOW_BASE,
  localparam int unsigned WORDS = BUF_BYTES / 4,
  localparam int unsigned AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fillEn,
  input  logic [AW-1:0]     fillIdx,
  input  logic [31:0]       fillData,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWide,
  input  logic [OP_W-1:0]   reqOpA,
  input  logic [OP_W-1:0]   reqOpB,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic [DEST_W-1:0] reqDest,
  output logic              outValid,
  input  logic              outReady,
  output logic [63:0]       outData,
  output logic [DEST_W-1:0] outDest,
  output logic              outLast,
  output logic              errPulse,
  output logic              doneOut
);
  dpStrobe_t     strobe;
  dpStatus_t     status;
  logic [AW-1:0] rdIdxLo, rdIdxHi;
  logic [31:0]   rdLo, rdHi;

  rbuf_store #(.WORDS(WORDS)) uStore (
    .clk(clk), .fillEn(fillEn), .fillIdx(fillIdx), .fillData(fillData),
    .rdIdxLo(rdIdxLo), .rdIdxHi(rdIdxHi), .rdLo(rdLo), .rdHi(rdHi)
  );

  rbuf_pack_dp #(
    .OP_W(OP_W), .CNT_W(CNT_W), .DEST_W(DEST_W),
    .BUF_BYTES(BUF_BYTES), .BASE(BASE)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqWide(reqWide), .reqOpA(reqOpA), .reqOpB(reqOpB),
    .reqCount(reqCount), .reqDest(reqDest),
    .rdLo(rdLo), .rdHi(rdHi), .rdIdxLo(rdIdxLo), .rdIdxHi(rdIdxHi),
    .status(status), .outData(outData), .outDest(outDest), .outLast(outLast)
  );

  rbuf_read_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .outReady(outReady),
    .status(status), .reqReady(reqReady), .outValid(outValid),
    .errPulse(errPulse), .doneOut(doneOut), .strobe(strobe)
  );

  // R10: tag and last flag hold under backpressure
  a_r10_tag_stable: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outDest) && $stable(outLast));

  // R10: no new request is taken while beats are pending
  a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !outValid);
endmodule

// File: tb/tb_rbuf_read_packer.sv
module tb_rbuf_read_packer;
  localparam int BUF = 256;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fillEn = 1'b0;
  logic [5:0]  fillIdx = '0;
  logic [31:0] fillData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWide = 1'b0;
  logic [15:0] reqOpA = '0, reqOpB = '0;
  logic [3:0]  reqCount = '0;
  logic [15:0] reqDest = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [63:0] outData;
  logic [15:0] outDest;
  logic        outLast;
  logic        errPulse, doneOut;

  int total = 0;
  int bad = 0;
  bit alt = 0;
  int rdyCnt = 0;

  always #4 clk = ~clk;

  rbuf_read_packer dut (
    .clk(clk), .rstN(rstN), .fillEn(fillEn), .fillIdx(fillIdx), .fillData(fillData),
    .reqValid(reqValid), .reqReady(reqReady), .reqWide(reqWide),
    .reqOpA(reqOpA), .reqOpB(reqOpB), .reqCount(reqCount), .reqDest(reqDest),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outDest(outDest),
    .outLast(outLast), .errPulse(errPulse), .doneOut(doneOut)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pb(input int o);
    return alt ? 8'(o ^ 'h5a) : 8'(o * 37 + 11);
  endfunction

  function automatic logic [31:0] w32(input int o);
    return {pb(o), pb(o + 1), pb(o + 2), pb(o + 3)};
  endfunction

  task automatic fillAll();
    for (int i = 0; i < BUF / 4; i++) begin
      @(negedge clk);
      fillEn = 1'b1; fillIdx = 6'(i); fillData = w32(4 * i);
    end
    @(negedge clk);
    fillEn = 1'b0;
  endtask

  task automatic runReq(input bit wide, input logic [15:0] a, input logic [15:0] b,
                        input int cnt, input logic [15:0] dest, input string tag);
    int sum = int'(a) + int'(b);
    int off = sum - 'h2000;
    int bw = wide ? 8 : 4;
    bit expErr = (sum < 'h2000) || (off % bw != 0) || (off + cnt * bw > BUF) ||
                 (wide && (dest % 8 != 0));
    int beats = 0;
    bit sawErr = 0, sawDone = 0, stallPrev = 0;
    logic [15:0] heldDest = '0;
    logic heldLast = 1'b0;
    int guard = 0;
    @(negedge clk);
    check(reqReady, "R10 idle ready", 64'(reqReady), 64'd1);
    reqValid = 1'b1; reqWide = wide; reqOpA = a; reqOpB = b;
    reqCount = 4'(cnt); reqDest = dest;
    @(negedge clk);
    reqValid = 1'b0;
    while (!sawErr && !sawDone && guard < 300) begin
      guard++;
      rdyCnt++;
      outReady = (rdyCnt % 3) != 2;
      if (errPulse) sawErr = 1;
      if (doneOut) sawDone = 1;
      if (outValid) begin
        if (reqReady) check(0, "R10 ready while busy", 64'(reqReady), 64'd0);
        if (stallPrev && (outDest != heldDest || outLast != heldLast))
          check(0, "R10 hold under stall", 64'(outDest), 64'(heldDest));
        if (outReady) begin
          logic [63:0] expD;
          logic [15:0] expT;
          if (wide) begin
            expD = {w32(off + 8 * beats + 4), w32(off + 8 * beats)};
            expT = dest + 16'(8 * beats);
          end else begin
            expD = {32'h0, w32(off + 4 * beats)};
            expT = dest + 16'(beats);
          end
          check(outData == expD, wide ? "R3 wide packing" : "R2 narrow packing", outData, expD);
          check(outDest == expT, "R4 dest tag", 64'(outDest), 64'(expT));
          check(outLast == (beats == cnt - 1), "R5 last flag", 64'(outLast), 64'(beats == cnt - 1));
          beats++;
        end
        stallPrev = !outReady;
        heldDest = outDest;
        heldLast = outLast;
      end else begin
        stallPrev = 0;
      end
      if (!sawErr && !sawDone) @(negedge clk);
    end
    outReady = 1'b0;
    if (expErr) begin
      check(sawErr && beats == 0 && !sawDone, {tag, " rejected"}, 64'(beats), 64'd0);
    end else begin
      check(sawDone && !sawErr, {tag, " completion"}, 64'(sawErr), 64'd0);
      check(beats == cnt, "R5 beat count", 64'(beats), 64'(cnt));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 64'd0, 64'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "reset reqReady", 64'(reqReady), 64'd1);
    check(outValid == 1'b0, "reset outValid", 64'(outValid), 64'd0);
    check(!errPulse && !doneOut, "reset pulses", {errPulse, doneOut}, 64'd0);

    fillAll();  // R11 initial fill

    // sweep aligned offsets, both widths, several counts (R1 R2 R3 R4 R5 R8)
    for (int w = 0; w < 2; w++) begin
      for (int off = 0; off < BUF; off += (w == 1 ? 8 : 4)) begin
        int cnts[4] = '{0, 1, 2, 7};
        for (int c = 0; c < 4; c++) begin
          int k = off % 7;
          logic [15:0] d = (w == 1) ? 16'(off * 2) : 16'(off % 13);
          runReq(w[0], 16'('h1f00 + k), 16'('h100 + off - k), cnts[c], d, "R1 sweep");
        end
      end
    end
    // full-length counts
    runReq(1'b0, 16'h2000, 16'h0000, 15, 16'hfff8, "R4 wrap narrow");
    runReq(1'b1, 16'h1000, 16'h1000, 15, 16'hffc0, "R4 wrap wide");
    // R8 zero count
    runReq(1'b1, 16'h2010, 16'h0000, 0, 16'h0000, "R8 zero");
    // R6 misaligned offsets
    runReq(1'b0, 16'h2001, 16'h0000, 2, 16'h0, "R6 narrow misaligned");
    runReq(1'b0, 16'h2000, 16'h0002, 1, 16'h0, "R6 narrow misaligned");
    runReq(1'b1, 16'h2004, 16'h0000, 1, 16'h0, "R6 wide misaligned");
    // R7 destination alignment
    runReq(1'b1, 16'h2000, 16'h0008, 1, 16'h0004, "R7 dest misaligned");
    runReq(1'b0, 16'h2000, 16'h0008, 1, 16'h0004, "R7 narrow dest free");
    // R1 window bounds
    runReq(1'b0, 16'h1ff0, 16'h000c, 1, 16'h0, "R1 below base");
    runReq(1'b1, 16'h2000, 16'h00f8, 2, 16'h0, "R1 overrun");
    runReq(1'b1, 16'h2000, 16'h00f8, 1, 16'h0, "R1 last row");
    runReq(1'b0, 16'hffff, 16'hffff, 1, 16'h0, "R1 carry sum");
    // R9 repeated reads return the same data
    runReq(1'b1, 16'h2000, 16'h0040, 4, 16'h0100, "R9 read one");
    runReq(1'b1, 16'h2000, 16'h0040, 4, 16'h0100, "R9 read two");
    runReq(1'b0, 16'h2000, 16'h0040, 8, 16'h0003, "R9 read three");
    // R11 refill changes what later reads return
    alt = 1;
    fillAll();
    runReq(1'b1, 16'h2000, 16'h0000, 6, 16'h0000, "R11 refilled wide");
    runReq(1'b0, 16'h2080, 16'h0004, 9, 16'h0010, "R11 refilled narrow");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule